// File: doc/BRIEF.md
# Segmented Address Translation and Check Unit

This block turns a segment register index and an offset into a linear address. It reads a small register file of cached segment state. Each entry holds a selector, a base, a limit, a present flag, a descriptor-class flag, a 4-bit type, a granularity flag, a 64-bit code flag and a flag that marks the cached base as valid. While it forms the address, it checks the segment's presence, type and limit against the access and returns a 3-bit status.

The core drives four mode inputs: real mode, virtual-8086 mode, long mode active, and the 64-bit flag of the code segment in use. A request has a valid strobe and a flag that picks data access or code fetch. The address and status are registered and come back one clock later, marked by a one-cycle valid pulse. A load port writes one cache entry per cycle. If a load and a lookup hit the same entry in the same cycle, the lookup sees the new value.

Top module: `seg_xlat_unit`

## Requirements
- R1: In real or virtual-8086 mode only offset[15:0] is used. It is added to base[31:0] when the entry's base-valid flag is set, and otherwise to the selector shifted left by 4. The sum wraps at 32 bits, bits 63:32 of the result are zero, and the status is always 0 (success), whatever the present, type and limit fields hold.
- R2: For a data access, when long mode is active and the code-segment 64-bit input is set, indices 0 to 3 (ES=0, CS=1, SS=2, DS=3) give the offset unchanged. Indices 4 (FS) and 5 (GS) give the full 64-bit base plus the offset. No limit check is made.
- R3: In every other protected case, the address is base[31:0] plus offset[31:0], wrapped to 32 bits, with bits 63:32 zero.
- R4: Outside real and virtual-8086 mode, an entry whose present flag is clear gives status 3 (not present). This check comes before any type check, for both data access and code fetch.
- R5: A data access to a present segment with the class flag set and type[3]=1 (code) or type[2]=0 (expand-up data) gives status 1 (out of bounds) when the full 64-bit offset is greater than the limit. Otherwise it gives status 0.
- R6: For expand-down data (type[3]=0, type[2]=1), a data access gives status 1 when the offset is less than or equal to the limit. It also gives status 1 when granularity is clear and the offset exceeds 0xFFFF. Otherwise it gives status 0.
- R7: A data access to a present segment whose class flag is clear (system type) gives status 2 (invalid selector).
- R8: A code fetch from a present segment whose class flag is clear or whose type[3] is 0 gives status 4 (not code). If long mode is active and the entry's own 64-bit flag is set, the result is the offset unchanged with status 0. Otherwise offset[31:0] is compared with the limit, and the fetch passes when it is less than or equal to the limit.
- R9: Each accepted request gives exactly one response, with rsp_valid high for the single cycle after the cycle of req_valid. Status codes are 0 success, 1 out of bounds, 2 invalid selector, 3 not present, 4 not code.
- R10: A load and a lookup of the same entry in the same cycle resolve the lookup with the newly loaded contents. The load is also stored for later lookups.
- R11: After reset, rsp_valid is low and every entry is cleared, so a protected data lookup reports status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load strobe for the segment cache |
| ld_idx | input | 3 | Entry being loaded |
| ld_sel | input | 16 | Selector value |
| ld_base | input | 64 | Base address |
| ld_limit | input | 32 | Byte limit, already scaled by granularity |
| ld_present | input | 1 | Present flag |
| ld_sbit | input | 1 | Descriptor class flag (1 = code/data) |
| ld_type | input | 4 | Type field |
| ld_gran | input | 1 | Granularity flag |
| ld_long | input | 1 | 64-bit code flag |
| ld_base_ok | input | 1 | Cached base is valid |
| mode_real | input | 1 | Real mode |
| mode_v86 | input | 1 | Virtual-8086 mode |
| mode_lma | input | 1 | Long mode active |
| cs_long | input | 1 | 64-bit flag of the current code segment |
| req_valid | input | 1 | Request strobe |
| req_idx | input | 3 | Segment index of the request |
| req_fetch | input | 1 | 1 = code fetch, 0 = data access |
| req_offset | input | 64 | Offset |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_lin | output | 64 | Linear address (meaningful on success) |
| rsp_status | output | 3 | Status code |

## Verification
The bench puts the limit checks at their exact edges. It tests offset equal to the limit and one above it for expand-up data. For expand-down data it tests the inverted edge and the 0xFFFF ceiling, once with granularity clear and once with it set. A design that misses the inversion, or compares with the wrong strictness, gives the opposite status at exactly these points.

It also sends an offset with high bits set, once as a data access and once as a code fetch. The data access must fail, because it compares all 64 bits. The fetch must pass, because it compares only the low 32 bits. A unit that truncates in both cases, or in neither, reports the wrong result.

Long mode is checked on the four zero-base segments and on the two that keep their base. Real mode is checked with a base that wraps at 32 bits. Last, a load and a lookup of the same entry are issued together with a limit change. A unit without the forwarding path would report the old limit's verdict.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
   localparam int SEL_W  = 16;
   localparam int ADR_W  = 64;
   localparam int HALF_W = ADR_W / 2;
   localparam int LIM_W  = 32;
   localparam int TYP_W  = 4;
   localparam int RIX_W  = 3;
   localparam int SEG_FS = 4;
   localparam int SEG_GS = 5;
   localparam int NUM_SEG = 6;

   typedef enum logic [2:0] {
      XS_OK      = 3'd0,
      XS_BOUNDS  = 3'd1,
      XS_BADSEL  = 3'd2,
      XS_ABSENT  = 3'd3,
      XS_NOTCODE = 3'd4
   } xlat_status_e;

   typedef struct packed {
      logic              base_ok;
      logic [SEL_W-1:0]  sel;
      logic [ADR_W-1:0]  base;
      logic [LIM_W-1:0]  limit;
      logic              present;
      logic              sbit;
      logic [TYP_W-1:0]  typ;
      logic              gran;
      logic              lng;
   } seg_ent_t;
endpackage

// File: rtl/seg_cache_rf.sv
module seg_cache_rf
   import seg_xlat_pkg::*;
#(
   parameter int NSEG  = NUM_SEG,
   parameter int IDX_W = RIX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  seg_ent_t         wr_ent,
   input  logic [IDX_W-1:0] rd_idx,
   output seg_ent_t         rd_ent
);
   localparam int ENT_W = $bits(seg_ent_t);

   seg_ent_t ents [NSEG];

   for (genvar gi = 0; gi < NSEG; gi++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ents[gi] <= seg_ent_t'({ENT_W{1'b0}});
         else if (wr_en && (wr_idx == IDX_W'(gi)))
            ents[gi] <= wr_ent;
      end
   end

   always_comb begin
      rd_ent = seg_ent_t'({ENT_W{1'b0}});
      for (int k = 0; k < NSEG; k++)
         if (rd_idx == IDX_W'(k)) rd_ent = ents[k];
      if (wr_en && (wr_idx == rd_idx)) rd_ent = wr_ent;
   end
endmodule

// File: rtl/seg_lin_calc.sv
module seg_lin_calc
   import seg_xlat_pkg::*;
#(
   parameter int IDX_W = RIX_W
) (
   input  seg_ent_t         ent,
   input  logic [IDX_W-1:0] idx,
   input  logic [ADR_W-1:0] offset,
   input  logic             rm,
   input  logic             flat_long,
   input  logic             fetch,
   output logic [ADR_W-1:0] lin
);
   logic [HALF_W-1:0] rbase;
   logic              keeps_base;

   assign keeps_base = (idx == IDX_W'(SEG_FS)) || (idx == IDX_W'(SEG_GS));

   always_comb begin
      rbase = ent.base_ok ? ent.base[HALF_W-1:0]
                          : {{(HALF_W-SEL_W-4){1'b0}}, ent.sel, 4'b0000};
      if (rm)
         lin = {{HALF_W{1'b0}}, rbase + {{(HALF_W-16){1'b0}}, offset[15:0]}};
      else if (flat_long)
         lin = (!fetch && keeps_base) ? ent.base + offset : offset;
      else
         lin = {{HALF_W{1'b0}}, ent.base[HALF_W-1:0] + offset[HALF_W-1:0]};
   end
endmodule

// File: rtl/seg_rule_chk.sv
module seg_rule_chk
   import seg_xlat_pkg::*;
(
   input  seg_ent_t         ent,
   input  logic [ADR_W-1:0] offset,
   input  logic             rm,
   input  logic             flat_long,
   input  logic             fetch,
   output xlat_status_e     status
);
   logic [ADR_W-1:0] lim_x;
   logic             is_down;

   assign lim_x   = {{(ADR_W-LIM_W){1'b0}}, ent.limit};
   assign is_down = !ent.typ[3] && ent.typ[2];

   always_comb begin
      status = XS_OK;
      if (rm)
         status = XS_OK;
      else if (!ent.present)
         status = XS_ABSENT;
      else if (fetch) begin
         if (!(ent.sbit && ent.typ[3]))
            status = XS_NOTCODE;
         else if (!flat_long && (offset[LIM_W-1:0] > ent.limit))
            status = XS_BOUNDS;
      end
      else if (!ent.sbit)
         status = XS_BADSEL;
      else if (flat_long)
         status = XS_OK;
      else if (is_down) begin
         if ((!ent.gran && (offset > ADR_W'(64'hFFFF))) || (offset <= lim_x))
            status = XS_BOUNDS;
      end
      else if (offset > lim_x)
         status = XS_BOUNDS;
   end
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
   import seg_xlat_pkg::*;
#(
   parameter int NSEG  = NUM_SEG,
   parameter int IDX_W = RIX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [IDX_W-1:0]   ld_idx,
   input  logic [SEL_W-1:0]   ld_sel,
   input  logic [ADR_W-1:0]   ld_base,
   input  logic [LIM_W-1:0]   ld_limit,
   input  logic               ld_present,
   input  logic               ld_sbit,
   input  logic [TYP_W-1:0]   ld_type,
   input  logic               ld_gran,
   input  logic               ld_long,
   input  logic               ld_base_ok,
   input  logic               mode_real,
   input  logic               mode_v86,
   input  logic               mode_lma,
   input  logic               cs_long,
   input  logic               req_valid,
   input  logic [IDX_W-1:0]   req_idx,
   input  logic               req_fetch,
   input  logic [ADR_W-1:0]   req_offset,
   output logic               rsp_valid,
   output logic [ADR_W-1:0]   rsp_lin,
   output logic [2:0]         rsp_status
);
   if (NSEG < NUM_SEG) begin : g_bad_nseg
      $error("seg_xlat_unit: NSEG must cover all six segment registers");
   end
   if ((1 << IDX_W) < NSEG) begin : g_bad_idx
      $error("seg_xlat_unit: IDX_W too narrow for NSEG");
   end

   seg_ent_t     wr_ent, look;
   logic         rm, flat_long;
   logic [ADR_W-1:0] lin_c;
   xlat_status_e st_c;

   assign wr_ent = '{base_ok: ld_base_ok, sel: ld_sel, base: ld_base,
                     limit: ld_limit, present: ld_present, sbit: ld_sbit,
                     typ: ld_type, gran: ld_gran, lng: ld_long};

   assign rm        = mode_real || mode_v86;
   assign flat_long = mode_lma && (req_fetch ? look.lng : cs_long);

   seg_cache_rf #(.NSEG(NSEG), .IDX_W(IDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(ld_en), .wr_idx(ld_idx),
      .wr_ent(wr_ent), .rd_idx(req_idx), .rd_ent(look));

   seg_lin_calc #(.IDX_W(IDX_W)) u_lin (
      .ent(look), .idx(req_idx), .offset(req_offset), .rm(rm),
      .flat_long(flat_long), .fetch(req_fetch), .lin(lin_c));

   seg_rule_chk u_chk (
      .ent(look), .offset(req_offset), .rm(rm), .flat_long(flat_long),
      .fetch(req_fetch), .status(st_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_lin    <= '0;
         rsp_status <= 3'd0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_lin    <= lin_c;
            rsp_status <= st_c;
         end
      end
   end

   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R9
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R1
   real_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rm) |=> (rsp_status == 3'd0 && rsp_lin[ADR_W-1:HALF_W] == '0));
   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rm && !flat_long) |=> (rsp_lin[ADR_W-1:HALF_W] == '0));
   // R4
   absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rm && !look.present) |=> (rsp_status == 3'd3));
   // R8
   fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch && !rm && look.present && !(look.sbit && look.typ[3]))
      |=> (rsp_status == 3'd4));
endmodule

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 0;
   logic [2:0]  ld_idx = 0;
   logic [15:0] ld_sel = 0;
   logic [63:0] ld_base = 0;
   logic [31:0] ld_limit = 0;
   logic        ld_present = 0, ld_sbit = 0, ld_gran = 0, ld_long = 0, ld_base_ok = 0;
   logic [3:0]  ld_type = 0;
   logic        mode_real = 0, mode_v86 = 0, mode_lma = 0, cs_long = 0;
   logic        req_valid = 0;
   logic [2:0]  req_idx = 0;
   logic        req_fetch = 0;
   logic [63:0] req_offset = 0;
   logic        rsp_valid;
   logic [63:0] rsp_lin;
   logic [2:0]  rsp_status;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [63:0] q_lin[$];
   logic [2:0]  q_st[$];
   bit          q_cl[$];
   string       q_tag[$];

   always #4 clk = ~clk;

   seg_xlat_unit dut (.*);

   // monitor: pops expected items as responses arrive
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (q_st.size() == 0) begin
            fails++;
            $display("FAIL R9 unexpected response: got valid=1 expected 0");
         end else begin
            logic [63:0] el; logic [2:0] es; bit cl; string tg;
            el = q_lin.pop_front(); es = q_st.pop_front();
            cl = q_cl.pop_front();  tg = q_tag.pop_front();
            if (rsp_status !== es || (cl && rsp_lin !== el)) begin
               fails++;
               $display("FAIL %s: got st=%0d lin=%h expected st=%0d lin=%h",
                        tg, rsp_status, rsp_lin, es, el);
            end
         end
      end
   end

   task automatic set_ld(input [2:0] i, input [15:0] s, input [63:0] b,
                         input [31:0] l, input bit p, input bit sb,
                         input [3:0] t, input bit g, input bit lg, input bit bo);
      ld_en = 1; ld_idx = i; ld_sel = s; ld_base = b; ld_limit = l;
      ld_present = p; ld_sbit = sb; ld_type = t; ld_gran = g;
      ld_long = lg; ld_base_ok = bo;
   endtask

   task automatic load(input [2:0] i, input [15:0] s, input [63:0] b,
                       input [31:0] l, input bit p, input bit sb,
                       input [3:0] t, input bit g, input bit lg, input bit bo);
      @(negedge clk);
      set_ld(i, s, b, l, p, sb, t, g, lg, bo);
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic push_req(input [2:0] i, input bit f, input [63:0] off,
                           input [63:0] el, input [2:0] es, input bit cl,
                           input string tg);
      req_valid = 1; req_idx = i; req_fetch = f; req_offset = off;
      q_lin.push_back(el); q_st.push_back(es); q_cl.push_back(cl); q_tag.push_back(tg);
   endtask

   task automatic issue(input [2:0] i, input bit f, input [63:0] off,
                        input [63:0] el, input [2:0] es, input bit cl,
                        input string tg);
      @(negedge clk);
      push_req(i, f, off, el, es, cl, tg);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic set_mode(input bit r, input bit v, input bit l, input bit c);
      mode_real = r; mode_v86 = v; mode_lma = l; cs_long = c;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R11 rsp_valid in reset: got %b expected 0", rsp_valid);
      end
      rst_n = 1;
      // R11 cleared entry reports not present
      issue(3, 0, 64'h10, 64'h0, 3'd3, 0, "R11 cleared entry");

      // DS: base 0x1000_0000 limit 0xFFFF rw data, base valid
      load(3, 16'h1234, 64'h0000_0000_1000_0000, 32'hFFFF, 1, 1, 4'h3, 0, 0, 1);
      // ES: not present, base invalid
      load(0, 16'hF000, 64'hDEAD_BEEF_0000_0000, 32'h0, 0, 0, 4'h0, 0, 0, 0);

      // R1 real / v86
      set_mode(1, 0, 0, 0);
      issue(3, 0, 64'hABCD_0000_1234_5678, 64'h1000_5678, 3'd0, 1, "R1 cached base");
      issue(0, 0, 64'h0000_0000_0000_FFFF, 64'h000F_FFFF, 3'd0, 1, "R1 shifted selector");
      load(1, 16'hFFFF, 64'h0, 32'h0, 0, 0, 4'h0, 0, 0, 0);
      set_mode(0, 1, 0, 0);
      issue(1, 0, 64'hFFFF, 64'h0010_FFEF, 3'd0, 1, "R1 v86 selector max");
      load(2, 16'h0, 64'hFFFF_FFF0, 32'h0, 1, 1, 4'h6, 0, 0, 1);
      issue(2, 0, 64'h20, 64'h10, 3'd0, 1, "R1 32-bit wrap");

      // protected
      set_mode(0, 0, 0, 0);
      issue(3, 0, 64'hFFFF, 64'h1000_FFFF, 3'd0, 1, "R5 offset at limit");
      issue(3, 0, 64'h1_0000, 64'h0, 3'd1, 0, "R5 offset above limit");
      issue(3, 0, 64'h1_0000_0000, 64'h0, 3'd1, 0, "R5 high offset bits");
      issue(0, 0, 64'h0, 64'h0, 3'd3, 0, "R4 data not present");
      load(5, 16'h0, 64'h0000_0001_FFFF_FFF0, 32'hFFFF_FFFF, 1, 1, 4'h2, 1, 0, 1);
      issue(5, 0, 64'h20, 64'h10, 3'd0, 1, "R3 protected wrap");

      // R6 expand-down
      load(2, 16'h0, 64'h2000, 32'h0FFF, 1, 1, 4'h6, 0, 0, 1);
      issue(2, 0, 64'h0FFF, 64'h0, 3'd1, 0, "R6 offset at limit");
      issue(2, 0, 64'h1000, 64'h3000, 3'd0, 1, "R6 offset above limit");
      issue(2, 0, 64'h1_0000, 64'h0, 3'd1, 0, "R6 byte ceiling");
      load(2, 16'h0, 64'h2000, 32'h0FFF, 1, 1, 4'h6, 1, 0, 1);
      issue(2, 0, 64'h1_0000, 64'h1_2000, 3'd0, 1, "R6 page granular");

      // R7 system type on FS
      load(4, 16'h0, 64'h0, 32'hFFFF, 1, 0, 4'h9, 0, 0, 1);
      issue(4, 0, 64'h0, 64'h0, 3'd2, 0, "R7 system type");

      // R2 long mode data
      set_mode(0, 0, 1, 1);
      issue(3, 0, 64'h0000_7FFF_0000_0000, 64'h0000_7FFF_0000_0000, 3'd0, 1, "R2 zero base DS");
      load(4, 16'h0, 64'h0000_1000_0000_0000, 32'h0, 1, 1, 4'h3, 0, 0, 1);
      issue(4, 0, 64'h10, 64'h0000_1000_0000_0010, 3'd0, 1, "R2 FS keeps base");
      set_mode(0, 0, 1, 0);
      issue(3, 0, 64'h100, 64'h1000_0100, 3'd0, 1, "R3 compatibility mode");

      // R8 code fetch
      set_mode(0, 0, 0, 0);
      load(1, 16'h8, 64'h4000_0000, 32'hFF, 1, 1, 4'hB, 0, 0, 1);
      issue(1, 1, 64'hFF, 64'h4000_00FF, 3'd0, 1, "R8 fetch at limit");
      issue(1, 1, 64'h100, 64'h0, 3'd1, 0, "R8 fetch above limit");
      issue(1, 1, 64'h1_0000_0010, 64'h4000_0010, 3'd0, 1, "R8 fetch truncated compare");
      issue(3, 1, 64'h0, 64'h0, 3'd4, 0, "R8 fetch from data");
      load(4, 16'h0, 64'h0, 32'hFFFF, 1, 0, 4'hB, 0, 0, 1);
      issue(4, 1, 64'h0, 64'h0, 3'd4, 0, "R8 fetch from system");
      issue(0, 1, 64'h0, 64'h0, 3'd3, 0, "R4 fetch not present");
      load(1, 16'h8, 64'h4000_0000, 32'hFF, 1, 1, 4'hB, 0, 1, 1);
      set_mode(0, 0, 1, 0);
      issue(1, 1, 64'h1234_5678_9ABC, 64'h1234_5678_9ABC, 3'd0, 1, "R8 fetch long flat");

      // R10 same-cycle load and lookup
      set_mode(0, 0, 0, 0);
      @(negedge clk);
      set_ld(3, 16'h0, 64'h5000, 32'hF, 1, 1, 4'h2, 0, 0, 1);
      push_req(3, 0, 64'h10, 64'h0, 3'd1, 0, "R10 forwarded limit");
      @(negedge clk);
      ld_en = 0; req_valid = 0;
      issue(3, 0, 64'h5, 64'h5005, 3'd0, 1, "R10 stored entry");

      repeat (4) @(negedge clk);
      checks++;
      if (q_st.size() != 0) begin
         fails++;
         $display("FAIL R9 missing responses: got %0d pending expected 0", q_st.size());
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule